// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a bank of 32-bit system control registers on a simple bus. Each access takes one cycle and carries an address, a write enable, a read enable and write data. A key register gates writes. Writing the magic value unlocks the bank, and writing any other value locks it. A write made while the bank is locked still lands, but it raises a lock-violation pulse that the rest of the chip can watch.

The bank holds several kinds of register:
- Revision words, which are read-only.
- Reset-control and strap registers. A write to one of these only sets bits. Each has a companion offset where a write clears bits.
- Protect words. While a protect word is nonzero, its strap register is frozen.
- PLL extension words, which always read back as locked.
- A random-data word. Every read of it steps an internal LFSR.

Every other word in the space is a plain read/write register. Read data is combinational, so it is valid in the same cycle as the read enable. The two flags are registered and pulse for one cycle, in the cycle after the access that caused them.

Top module: `sysctl_regbank`

## Requirements
- R1: Reset loads the following values. Every other word resets to 0.

  | Offset | Value |
  |---|---|
  | 0x040 | 0xF7CFFFDC |
  | 0x050 | 0xFFFFFFFC |
  | 0x080 | 0xEFF43E8B |
  | 0x090 | 0xFFF0FFF0 |
  | 0x200 | 0x1000405F |
  | 0x004 and 0x014 | 0x05000303 |
  | 0x500 and 0x510 | the two strap input pins |
  | 0x000 (key) | key_init zero-extended |

- R2: A write of 0x1688A8A8 to offset 0x000 stores 1, and a write of any other value there stores 0. The stored value reads back at 0x000.
- R3: An aligned, in-range write to any nonzero offset while the key word holds 0 sets lock_viol high in the next cycle, for one cycle. The write itself still takes effect. Writes to offset 0x000, and any write while the key word holds 1, leave lock_viol low.
- R4: A write to 0x040, 0x050, 0x500 or 0x510 ORs the write data into that register.
- R5: A write to 0x044, 0x054, 0x504 or 0x514 clears, in the register one word below (0x040, 0x050, 0x500 or 0x510), the bits that are 1 in the write data.
- R6: A write to 0x500 is dropped while the word at 0x508 is nonzero. Likewise, a write to 0x510 is dropped while the word at 0x518 is nonzero. Neither case raises acc_err.
- R7: A read of 0x204, 0x224 or 0x244 returns the stored value with bit 31 forced to 1.
- R8: Writes to 0x004, 0x014 and 0x540 are dropped. Each one sets acc_err high in the next cycle, for one cycle.
- R9: A read of 0x540 returns the LFSR state and then advances it, whatever value the control word at 0x524 holds. Reset loads the seed, 0x00000001. The next state is (s >> 1) XOR (s[0] ? 0x80200003 : 0).
- R10: A read at an offset of 0xE20 or above returns 0 and raises no flag. A write there is dropped and sets acc_err in the next cycle. The word at 0xE1C is an ordinary register.
- R11: Any access with address bits [1:0] nonzero is ignored. A read of this kind returns 0. Either kind sets acc_err in the next cycle.
- R12: All other in-range words are plain read/write storage. rdata is 0 whenever rd_en is low, and acc_err stays low in the cycle after an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| key_init | input | 1 | Key word value loaded at reset |
| strap1_init | input | 32 | Reset value of strap word 0x500 |
| strap2_init | input | 32 | Reset value of strap word 0x510 |
| rdata | output | 32 | Combinational read data |
| lock_viol | output | 1 | One-cycle pulse for a write made while locked |
| acc_err | output | 1 | One-cycle pulse for an illegal access |

## Verification
The bench uses the default parameters: a 12-bit address, 904 words and LFSR seed 1. With 12 address bits, the last legal word (0xE1C), the first illegal word (0xE20) and the top of the address space (0xFFC) can all be reached through the port, so both sides of the range limit are exercised. Seed 1 keeps the expected random sequence short to compute. A second reset with key_init high shows that the pin sets the key state and that the LFSR restarts from the seed.

// File: rtl/sysctl_regbank.sv
module sysctl_regbank #(
  parameter int          ADDR_W     = 12,
  parameter int          NWORDS     = 904,
  parameter logic [31:0] UNLOCK_KEY = 32'h1688A8A8,
  parameter logic [31:0] REV_ID     = 32'h05000303,
  parameter logic [31:0] RNG_SEED   = 32'h00000001,
  parameter logic [31:0] RNG_TAPS   = 32'h80200003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  input  logic              key_init,
  input  logic [31:0]       strap1_init,
  input  logic [31:0]       strap2_init,
  output logic [31:0]       rdata,
  output logic              lock_viol,
  output logic              acc_err
);
  localparam int IW = ADDR_W - 2;
  localparam logic [IW:0] LIMIT = (IW+1)'(NWORDS);

  localparam logic [IW-1:0] I_KEY   = IW'(0);
  localparam logic [IW-1:0] I_REV1  = IW'(1);
  localparam logic [IW-1:0] I_REV2  = IW'(5);
  localparam logic [IW-1:0] I_RST1  = IW'(16);
  localparam logic [IW-1:0] I_RST1C = IW'(17);
  localparam logic [IW-1:0] I_RST2  = IW'(20);
  localparam logic [IW-1:0] I_RST2C = IW'(21);
  localparam logic [IW-1:0] I_CSTP1 = IW'(32);
  localparam logic [IW-1:0] I_CSTP2 = IW'(36);
  localparam logic [IW-1:0] I_PLLP  = IW'(128);
  localparam logic [IW-1:0] I_PLLH  = IW'(129);
  localparam logic [IW-1:0] I_PLLM  = IW'(137);
  localparam logic [IW-1:0] I_PLLE  = IW'(145);
  localparam logic [IW-1:0] I_STR1  = IW'(320);
  localparam logic [IW-1:0] I_STR1C = IW'(321);
  localparam logic [IW-1:0] I_STR1P = IW'(322);
  localparam logic [IW-1:0] I_STR2  = IW'(324);
  localparam logic [IW-1:0] I_STR2C = IW'(325);
  localparam logic [IW-1:0] I_STR2P = IW'(326);
  localparam logic [IW-1:0] I_RNG   = IW'(336);

  logic [31:0] regs [NWORDS];
  logic [31:0] lfsr;
  logic [31:0] stored, rd_val;

  wire [IW-1:0] widx     = addr[ADDR_W-1:2];
  wire          aligned  = (addr[1:0] == 2'b00);
  wire          in_range = ({1'b0, widx} < LIMIT);
  wire          is_ro    = (widx == I_REV1) || (widx == I_REV2) || (widx == I_RNG);
  wire          is_pll   = (widx == I_PLLH) || (widx == I_PLLM) || (widx == I_PLLE);
  wire          wr_ok    = wr_en && aligned && in_range;
  wire          rd_ok    = rd_en && aligned && in_range;
  wire          locked   = (regs[I_KEY] == 32'd0);
  wire          frozen   = ((widx == I_STR1) && (regs[I_STR1P] != 32'd0)) ||
                           ((widx == I_STR2) && (regs[I_STR2P] != 32'd0));
  wire [31:0]   lfsr_nx  = {1'b0, lfsr[31:1]} ^ (lfsr[0] ? RNG_TAPS : 32'd0);

  assign stored = in_range ? regs[widx] : 32'd0;

  always_comb begin
    rd_val = stored;
    if (widx == I_RNG) rd_val = lfsr;
    else if (is_pll)   rd_val = stored | 32'h80000000;
  end

  assign rdata = rd_ok ? rd_val : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) regs[i[IW-1:0]] <= 32'd0;
      regs[I_KEY]   <= {31'd0, key_init};
      regs[I_REV1]  <= REV_ID;
      regs[I_REV2]  <= REV_ID;
      regs[I_RST1]  <= 32'hF7CFFFDC;
      regs[I_RST2]  <= 32'hFFFFFFFC;
      regs[I_CSTP1] <= 32'hEFF43E8B;
      regs[I_CSTP2] <= 32'hFFF0FFF0;
      regs[I_PLLP]  <= 32'h1000405F;
      regs[I_STR1]  <= strap1_init;
      regs[I_STR2]  <= strap2_init;
      lfsr          <= RNG_SEED;
      lock_viol     <= 1'b0;
      acc_err       <= 1'b0;
    end else begin
      lock_viol <= wr_ok && (widx != I_KEY) && locked;
      acc_err   <= ((wr_en || rd_en) && !aligned) ||
                   (wr_en && aligned && (!in_range || is_ro));
      if (rd_ok && (widx == I_RNG)) lfsr <= lfsr_nx;
      if (wr_ok && !is_ro) begin
        case (widx)
          I_KEY:          regs[I_KEY]  <= {31'd0, (wdata == UNLOCK_KEY)};
          I_RST1, I_RST2: regs[widx]   <= regs[widx] | wdata;
          I_STR1, I_STR2: if (!frozen) regs[widx] <= regs[widx] | wdata;
          I_RST1C:        regs[I_RST1] <= regs[I_RST1] & ~wdata;
          I_RST2C:        regs[I_RST2] <= regs[I_RST2] & ~wdata;
          I_STR1C:        regs[I_STR1] <= regs[I_STR1] & ~wdata;
          I_STR2C:        regs[I_STR2] <= regs[I_STR2] & ~wdata;
          default:        regs[widx]   <= wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter int          ADDR_W     = 12,
  parameter int          NWORDS     = 904,
  parameter logic [31:0] UNLOCK_KEY = 32'h1688A8A8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [31:0]       wdata,
  input logic              key_init,
  input logic [31:0]       rdata,
  input logic              lock_viol,
  input logic              acc_err
);
  logic [31:0] a32;
  logic        unlocked_sh;
  assign a32 = {{(32-ADDR_W){1'b0}}, addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlocked_sh <= key_init;
    else if (wr_en && a32 == 32'd0) unlocked_sh <= (wdata == UNLOCK_KEY);
  end

  wire legal = (addr[1:0] == 2'b00) && (a32 < NWORDS * 4);

  p_lock_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && legal && a32 != 32'd0 && !unlocked_sh |=> lock_viol);
  p_lock_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || unlocked_sh) |=> !lock_viol);
  p_pll_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (a32 == 32'h204 || a32 == 32'h224 || a32 == 32'h244) |-> rdata[31]);
  p_range_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && a32 >= NWORDS * 4 |-> rdata == 32'd0);
  p_range_wr_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && a32 >= NWORDS * 4 |=> acc_err);
  p_misalign_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && addr[1:0] != 2'b00 |=> acc_err);
  p_misalign_rd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr[1:0] != 2'b00 |-> rdata == 32'd0);
  p_idle_rdata_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == 32'd0);
  p_idle_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !rd_en |=> !acc_err);
endmodule

bind sysctl_regbank sysctl_regbank_chk #(
  .ADDR_W(ADDR_W), .NWORDS(NWORDS), .UNLOCK_KEY(UNLOCK_KEY)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .key_init(key_init), .rdata(rdata),
  .lock_viol(lock_viol), .acc_err(acc_err)
);

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        key_init = 1'b0;
  logic [31:0] strap1_init = 32'h000000A5;
  logic [31:0] strap2_init = 32'h12340000;
  logic [31:0] rdata;
  logic        lock_viol, acc_err;
  int          errors = 0, checks = 0;

  always #2 clk = ~clk;

  sysctl_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .key_init(key_init), .strap1_init(strap1_init),
    .strap2_init(strap2_init), .rdata(rdata), .lock_viol(lock_viol),
    .acc_err(acc_err)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] e;
    logic        err;
    logic        lv;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 63;
  localparam vec_t VEC [NV] = '{
    '{1'b0,12'h000,32'h0,32'h00000000,1'b0,1'b0,4'd1},  // R1 key from pin
    '{1'b0,12'h040,32'h0,32'hF7CFFFDC,1'b0,1'b0,4'd1},  // R1
    '{1'b0,12'h050,32'h0,32'hFFFFFFFC,1'b0,1'b0,4'd1},  // R1
    '{1'b0,12'h080,32'h0,32'hEFF43E8B,1'b0,1'b0,4'd1},  // R1
    '{1'b0,12'h090,32'h0,32'hFFF0FFF0,1'b0,1'b0,4'd1},  // R1
    '{1'b0,12'h200,32'h0,32'h1000405F,1'b0,1'b0,4'd1},  // R1
    '{1'b0,12'h004,32'h0,32'h05000303,1'b0,1'b0,4'd1},  // R1
    '{1'b0,12'h014,32'h0,32'h05000303,1'b0,1'b0,4'd1},  // R1
    '{1'b0,12'h500,32'h0,32'h000000A5,1'b0,1'b0,4'd1},  // R1 strap pin
    '{1'b0,12'h510,32'h0,32'h12340000,1'b0,1'b0,4'd1},  // R1 strap pin
    '{1'b0,12'h300,32'h0,32'h00000000,1'b0,1'b0,4'd1},  // R1 others zero
    '{1'b1,12'h300,32'hDEADBEEF,32'h0,1'b0,1'b1,4'd3},  // R3 locked write flags
    '{1'b0,12'h300,32'h0,32'hDEADBEEF,1'b0,1'b0,4'd3},  // R3 write still lands
    '{1'b1,12'h000,32'h12345678,32'h0,1'b0,1'b0,4'd2},  // R2 wrong key
    '{1'b0,12'h000,32'h0,32'h00000000,1'b0,1'b0,4'd2},  // R2
    '{1'b1,12'h000,32'h1688A8A8,32'h0,1'b0,1'b0,4'd2},  // R2 magic
    '{1'b0,12'h000,32'h0,32'h00000001,1'b0,1'b0,4'd2},  // R2
    '{1'b1,12'h044,32'h000000FF,32'h0,1'b0,1'b0,4'd5},  // R5
    '{1'b0,12'h040,32'h0,32'hF7CFFF00,1'b0,1'b0,4'd5},  // R5
    '{1'b1,12'h040,32'h00000011,32'h0,1'b0,1'b0,4'd4},  // R4
    '{1'b0,12'h040,32'h0,32'hF7CFFF11,1'b0,1'b0,4'd4},  // R4
    '{1'b1,12'h054,32'hFFFF0000,32'h0,1'b0,1'b0,4'd5},  // R5
    '{1'b0,12'h050,32'h0,32'h0000FFFC,1'b0,1'b0,4'd5},  // R5
    '{1'b1,12'h050,32'h00000003,32'h0,1'b0,1'b0,4'd4},  // R4
    '{1'b0,12'h050,32'h0,32'h0000FFFF,1'b0,1'b0,4'd4},  // R4
    '{1'b1,12'h500,32'h00000F00,32'h0,1'b0,1'b0,4'd4},  // R4
    '{1'b0,12'h500,32'h0,32'h00000FA5,1'b0,1'b0,4'd4},  // R4
    '{1'b1,12'h504,32'h00000005,32'h0,1'b0,1'b0,4'd5},  // R5
    '{1'b0,12'h500,32'h0,32'h00000FA0,1'b0,1'b0,4'd5},  // R5
    '{1'b1,12'h508,32'h00000001,32'h0,1'b0,1'b0,4'd6},  // R6 protect on
    '{1'b1,12'h500,32'hF0000000,32'h0,1'b0,1'b0,4'd6},  // R6 dropped
    '{1'b0,12'h500,32'h0,32'h00000FA0,1'b0,1'b0,4'd6},  // R6
    '{1'b1,12'h510,32'h000000FF,32'h0,1'b0,1'b0,4'd4},  // R4
    '{1'b1,12'h514,32'h00340000,32'h0,1'b0,1'b0,4'd5},  // R5
    '{1'b0,12'h510,32'h0,32'h120000FF,1'b0,1'b0,4'd5},  // R5
    '{1'b1,12'h518,32'h00000002,32'h0,1'b0,1'b0,4'd6},  // R6
    '{1'b1,12'h510,32'hFF000000,32'h0,1'b0,1'b0,4'd6},  // R6
    '{1'b0,12'h510,32'h0,32'h120000FF,1'b0,1'b0,4'd6},  // R6
    '{1'b0,12'h204,32'h0,32'h80000000,1'b0,1'b0,4'd7},  // R7
    '{1'b1,12'h224,32'h00001234,32'h0,1'b0,1'b0,4'd7},  // R7
    '{1'b0,12'h224,32'h0,32'h80001234,1'b0,1'b0,4'd7},  // R7
    '{1'b0,12'h244,32'h0,32'h80000000,1'b0,1'b0,4'd7},  // R7
    '{1'b1,12'h004,32'hFFFFFFFF,32'h0,1'b1,1'b0,4'd8},  // R8
    '{1'b0,12'h004,32'h0,32'h05000303,1'b0,1'b0,4'd8},  // R8
    '{1'b1,12'h014,32'h00000000,32'h0,1'b1,1'b0,4'd8},  // R8
    '{1'b0,12'h014,32'h0,32'h05000303,1'b0,1'b0,4'd8},  // R8
    '{1'b1,12'h540,32'h00000055,32'h0,1'b1,1'b0,4'd8},  // R8
    '{1'b1,12'hE20,32'h0000AAAA,32'h0,1'b1,1'b0,4'd10}, // R10
    '{1'b0,12'hE20,32'h0,32'h00000000,1'b0,1'b0,4'd10}, // R10
    '{1'b0,12'hFFC,32'h0,32'h00000000,1'b0,1'b0,4'd10}, // R10
    '{1'b1,12'hE1C,32'h5A5A5A5A,32'h0,1'b0,1'b0,4'd10}, // R10 last word
    '{1'b0,12'hE1C,32'h0,32'h5A5A5A5A,1'b0,1'b0,4'd10}, // R10
    '{1'b1,12'h302,32'h11111111,32'h0,1'b1,1'b0,4'd11}, // R11
    '{1'b0,12'h300,32'h0,32'hDEADBEEF,1'b0,1'b0,4'd11}, // R11 unchanged
    '{1'b0,12'h301,32'h0,32'h00000000,1'b1,1'b0,4'd11}, // R11
    '{1'b1,12'h000,32'h00000000,32'h0,1'b0,1'b0,4'd2},  // R2 relock
    '{1'b1,12'h080,32'h00000000,32'h0,1'b0,1'b1,4'd3},  // R3
    '{1'b0,12'h080,32'h0,32'h00000000,1'b0,1'b0,4'd3},  // R3
    '{1'b1,12'hE24,32'h00000001,32'h0,1'b1,1'b0,4'd10}, // R10 no lock flag
    '{1'b1,12'h000,32'h1688A8A8,32'h0,1'b0,1'b0,4'd2},  // R2
    '{1'b1,12'h524,32'h00000000,32'h0,1'b0,1'b0,4'd12}, // R12
    '{1'b1,12'h600,32'h13579BDF,32'h0,1'b0,1'b0,4'd12}, // R12
    '{1'b0,12'h600,32'h0,32'h13579BDF,1'b0,1'b0,4'd12}  // R12
  };

  task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_op(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic [31:0] e, input logic err, input logic lv, input int rq);
    @(negedge clk);
    addr = a; wdata = d; wr_en = wr; rd_en = !wr;
    #1;
    if (!wr) check(rq, "rdata", rdata, e);
    @(posedge clk);
    #1;
    check(rq, "acc_err", {31'd0, acc_err}, {31'd0, err});
    check(rq, "lock_viol", {31'd0, lock_viol}, {31'd0, lv});
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic do_reset(input logic k);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; key_init = k; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? 32'h80200003 : 32'h0);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] m;
    do_reset(1'b0);
    #1;
    check(1, "rdata after reset", rdata, 32'h0);        // R1, R12
    check(1, "acc_err after reset", {31'd0, acc_err}, 32'h0);
    check(1, "lock_viol after reset", {31'd0, lock_viol}, 32'h0);

    for (int i = 0; i < NV; i++)
      do_op(VEC[i].wr, VEC[i].a, VEC[i].d, VEC[i].e, VEC[i].err, VEC[i].lv, int'(VEC[i].rq));

    idle();
    @(posedge clk); #1;
    check(12, "idle acc_err", {31'd0, acc_err}, 32'h0);  // R12
    check(12, "idle rdata", rdata, 32'h0);

    m = 32'h00000001;                                     // R9 sequence, enable word 0
    for (int i = 0; i < 5; i++) begin
      do_op(1'b0, 12'h540, 32'h0, m, 1'b0, 1'b0, 9);
      m = step(m);
    end
    do_op(1'b1, 12'h524, 32'h1, 32'h0, 1'b0, 1'b0, 9);
    do_op(1'b0, 12'h540, 32'h0, m, 1'b0, 1'b0, 9);
    m = step(m);
    do_op(1'b1, 12'h540, 32'hFFFFFFFF, 32'h0, 1'b1, 1'b0, 8);  // R8: no LFSR step
    do_op(1'b0, 12'h540, 32'h0, m, 1'b0, 1'b0, 9);

    do_reset(1'b1);                                       // R1 key pin high
    do_op(1'b0, 12'h000, 32'h0, 32'h1, 1'b0, 1'b0, 1);
    do_op(1'b0, 12'h600, 32'h0, 32'h0, 1'b0, 1'b0, 1);
    do_op(1'b0, 12'h040, 32'h0, 32'hF7CFFFDC, 1'b0, 1'b0, 1);
    do_op(1'b1, 12'h300, 32'h1, 32'h0, 1'b0, 1'b0, 3);   // R3 unlocked, no flag
    do_op(1'b0, 12'h540, 32'h0, 32'h00000001, 1'b0, 1'b0, 9);
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule